// File: doc/BRIEF.md
# SD single-lane data block writer

This block sends one data block to an SD card on the DAT0 line in 1-bit bus mode. It starts once the single-block write command (or one block of a multi-block write) has already been accepted by the card. Command issue, card selection and block sequencing are handled elsewhere, and the writer is started once per block. The card erases internally, so no erase step comes first.

After `start`, the writer drives a low start bit. It then reads the payload from a local byte buffer and shifts it out with no gaps. A 16-bit CRC and a high end bit follow. The writer then releases DAT0 and waits two bit times. It reads the card's three-bit CRC status token, then waits while the card holds DAT0 low for busy. Finally it reports one of four outcomes with a one-cycle `done` pulse.

All DAT0 activity is paced by `bit_stb`, a one-cycle strobe issued once per SD clock period at the edge where the host updates DAT0. Outputs change at the clock edge where `bit_stb` is high, and `dat_i` is sampled at that same edge. The buffer port has a one-cycle read latency: `buf_data` must hold the byte at the `buf_addr` of the previous clock.

Top module: `sd_block_writer`

## Requirements
- R1: After reset the block is idle: `dat_oe`=0, `dat_o`=1, `done`=0, `card_clk_run`=0, `status`=0.
- R2: `dat_o` and `dat_oe` change only at edges where `bit_stb` is high. `card_clk_run` is high from the edge that accepts `start` up to the edge that raises `done`, and is low after that edge.
- R3: On successive strobes the block drives, with `dat_oe`=1, the following sequence. First a 0 start bit. Then BLOCK_BYTES bytes read from buffer addresses 0 upward, each sent MSB first. Then 16 CRC bits, MSB first. Then a 1 end bit. The CRC uses polynomial x^16+x^12+x^5+1 with an initial value of 0, computed over the payload bits in the order they are sent.
- R4: At the strobe after the end bit, `dat_oe` goes to 0. The `dat_i` values at that strobe and the next one are ignored. Sampling of `dat_i` begins at the third strobe after the end bit.
- R5: The first 0 sampled on `dat_i` starts the token. The next three samples form the code, first sample as MSB. Then one sample is taken for the token end bit. At the strobe that samples the token end bit, code 010 moves on to the busy phase. Code 101 finishes with status 1 (CRC error). Any other code finishes with status 2 (write error).
- R6: If eight samples in a row are high while the block waits for the token start, it finishes with status 3 (timeout) at the eighth sample.
- R7: In the busy phase, the first high sample finishes with status 0 (OK). If `busy_limit` low samples in a row are seen (`busy_limit` ≥ 1), the block finishes with status 3 at the last of them.
- R8: `done` is high for exactly one clock. `status` takes its new value at the same edge and keeps it until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one block transfer (taken when idle) |
| busy_limit | input | BUSY_W | Maximum number of busy (low) samples |
| bit_stb | input | 1 | One strobe per SD clock period |
| buf_addr | output | clog2(BLOCK_BYTES) | Payload buffer byte address |
| buf_data | input | 8 | Payload byte, one-cycle read latency |
| card_clk_run | output | 1 | Request that the SD clock runs |
| dat_o | output | 1 | DAT0 output value |
| dat_oe | output | 1 | DAT0 output enable |
| dat_i | input | 1 | DAT0 input value |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 CRC error, 2 write error, 3 timeout |

## Verification
Every result in this block is tied to a count of strobes, not of clocks. Each driven bit appears just after the strobe edge that produces it, and each outcome appears just after the strobe that samples its deciding `dat_i` bit. The bench pulses `bit_stb` itself and reads the outputs at the falling clock edge that follows each strobe. It numbers the response strobes from the end bit, and from the token delay, the code and the busy length it computes the exact strobe at which `done` and `status` are due. It also checks that `done` is gone one clock later. The turnaround strobes are sometimes driven low to show they are not sampled.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_SBIT, S_DATA, S_CRC, S_EBIT, S_TURN, S_WTOK, S_TOK, S_BUSY
    } sdw_state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_CRC_ERR = 2'd1,
        ST_WR_ERR  = 2'd2,
        ST_TIMEOUT = 2'd3
    } sdw_status_e;

    localparam logic [15:0] SDW_CRC_POLY   = 16'h1021;
    localparam logic [2:0]  SDW_TOK_ACCEPT = 3'b010;
    localparam logic [2:0]  SDW_TOK_CRCERR = 3'b101;
    localparam int          SDW_TURN_BITS  = 2;
    localparam int          SDW_TOK_WAIT   = 8;

endpackage

// File: rtl/sdw_crc16_step.sv
module sdw_crc16_step
    import sdw_pkg::*;
(
    input  logic [15:0] crc_i,
    input  logic        bit_i,
    output logic [15:0] crc_o
);
    logic fb;

    assign fb    = bit_i ^ crc_i[15];
    assign crc_o = {crc_i[14:0], 1'b0} ^ (fb ? SDW_CRC_POLY : 16'h0000);
endmodule

// File: rtl/sdw_tok_decode.sv
module sdw_tok_decode
    import sdw_pkg::*;
(
    input  logic [2:0]  code_i,
    output logic        accept_o,
    output sdw_status_e err_o
);
    assign accept_o = (code_i == SDW_TOK_ACCEPT);
    assign err_o    = (code_i == SDW_TOK_CRCERR) ? ST_CRC_ERR : ST_WR_ERR;
endmodule

// File: rtl/sd_block_writer.sv
module sd_block_writer
    import sdw_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int BUSY_W      = 16,
    localparam int AW         = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUSY_W-1:0] busy_limit,
    input  logic              bit_stb,
    output logic [AW-1:0]     buf_addr,
    input  logic [7:0]        buf_data,
    output logic              card_clk_run,
    output logic              dat_o,
    output logic              dat_oe,
    input  logic              dat_i,
    output logic              done,
    output logic [1:0]        status
);
    localparam logic [AW-1:0] LAST_BYTE = AW'(BLOCK_BYTES - 1);
    localparam logic [3:0]    TURN_LAST = 4'(SDW_TURN_BITS - 1);
    localparam logic [3:0]    WAIT_LAST = 4'(SDW_TOK_WAIT - 1);

    typedef struct packed {
        sdw_state_e  st;
        logic [AW-1:0] addr;
        logic [AW-1:0] byten;
        logic [7:0]  sh;
        logic [2:0]  bitn;
        logic [15:0] crc;
        logic [3:0]  cnt;
        logic [2:0]  tok;
        logic [BUSY_W-1:0] busy;
        logic        dat;
        logic        oe;
        logic        run;
        logic        done;
        sdw_status_e status;
    } regs_t;

    regs_t q, n;

    logic [15:0]       crc_nx;
    logic              tok_ok;
    sdw_status_e       tok_err;
    logic              fin;
    sdw_status_e       fin_st;
    logic [BUSY_W-1:0] busy_inc;

    sdw_crc16_step u_crc (
        .crc_i (q.crc),
        .bit_i (q.sh[7]),
        .crc_o (crc_nx)
    );

    sdw_tok_decode u_tok (
        .code_i   (q.tok),
        .accept_o (tok_ok),
        .err_o    (tok_err)
    );

    assign busy_inc = q.busy + 1'b1;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        fin    = 1'b0;
        fin_st = ST_OK;
        if (q.st == S_IDLE) begin
            n.oe   = 1'b0;
            n.dat  = 1'b1;
            n.addr = '0;
            n.run  = 1'b0;
            if (start) begin
                n.st  = S_SBIT;
                n.run = 1'b1;
            end
        end else if (bit_stb) begin
            case (q.st)
                S_SBIT: begin
                    n.dat   = 1'b0;
                    n.oe    = 1'b1;
                    n.sh    = buf_data;
                    n.addr  = q.addr + 1'b1;
                    n.bitn  = '0;
                    n.byten = '0;
                    n.crc   = '0;
                    n.st    = S_DATA;
                end
                S_DATA: begin
                    n.dat  = q.sh[7];
                    n.crc  = crc_nx;
                    n.sh   = {q.sh[6:0], 1'b0};
                    n.bitn = q.bitn + 1'b1;
                    if (q.bitn == 3'd7) begin
                        if (q.byten == LAST_BYTE) begin
                            n.st  = S_CRC;
                            n.cnt = '0;
                        end else begin
                            n.sh    = buf_data;
                            n.addr  = q.addr + 1'b1;
                            n.byten = q.byten + 1'b1;
                        end
                    end
                end
                S_CRC: begin
                    n.dat = q.crc[15];
                    n.crc = {q.crc[14:0], 1'b0};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == 4'd15) n.st = S_EBIT;
                end
                S_EBIT: begin
                    n.dat = 1'b1;
                    n.cnt = '0;
                    n.st  = S_TURN;
                end
                S_TURN: begin
                    n.oe  = 1'b0;
                    n.dat = 1'b1;
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == TURN_LAST) begin
                        n.st  = S_WTOK;
                        n.cnt = '0;
                    end
                end
                S_WTOK: begin
                    if (!dat_i) begin
                        n.st  = S_TOK;
                        n.cnt = '0;
                        n.tok = '0;
                    end else if (q.cnt == WAIT_LAST) begin
                        fin    = 1'b1;
                        fin_st = ST_TIMEOUT;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                S_TOK: begin
                    if (q.cnt < 4'd3) begin
                        n.tok = {q.tok[1:0], dat_i};
                        n.cnt = q.cnt + 1'b1;
                    end else if (tok_ok) begin
                        n.st   = S_BUSY;
                        n.busy = '0;
                    end else begin
                        fin    = 1'b1;
                        fin_st = tok_err;
                    end
                end
                S_BUSY: begin
                    if (dat_i) begin
                        fin    = 1'b1;
                        fin_st = ST_OK;
                    end else if (busy_inc == busy_limit) begin
                        fin    = 1'b1;
                        fin_st = ST_TIMEOUT;
                    end else begin
                        n.busy = busy_inc;
                    end
                end
                default: n.st = S_IDLE;
            endcase
        end
        if (fin) begin
            n.st     = S_IDLE;
            n.done   = 1'b1;
            n.status = fin_st;
            n.run    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.dat <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign buf_addr     = q.addr;
    assign dat_o        = q.dat;
    assign dat_oe       = q.oe;
    assign card_clk_run = q.run;
    assign done         = q.done;
    assign status       = q.status;

    AST_PINS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ($stable(dat_o) && $stable(dat_oe))); // R2
    AST_DRIVE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe |-> card_clk_run); // R2
    AST_RELEASE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_oe) |-> (dat_o && $past(dat_o))); // R4
    AST_TOK_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WTOK) |-> (q.cnt < 4'(SDW_TOK_WAIT))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> done); // R8
    AST_DONE_STOPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !card_clk_run); // R2

endmodule

// File: tb/tb_sd_block_writer.sv
`timescale 1ns/1ps
module tb_sd_block_writer;
    localparam int NB     = 16;
    localparam int BW     = 8;
    localparam int LIMIT  = 5;
    localparam int AWB    = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [BW-1:0] busy_limit = BW'(LIMIT);
    logic          bit_stb = 1'b0;
    logic [AWB-1:0] buf_addr;
    logic [7:0]    buf_data = 8'h00;
    logic          card_clk_run;
    logic          dat_o;
    logic          dat_oe;
    logic          dat_i = 1'b1;
    logic          done;
    logic [1:0]    status;

    int nchk = 0;
    int nbad = 0;
    int seed = 0;

    always #2.5 clk = ~clk;

    sd_block_writer #(.BLOCK_BYTES(NB), .BUSY_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy_limit(busy_limit),
        .bit_stb(bit_stb), .buf_addr(buf_addr), .buf_data(buf_data),
        .card_clk_run(card_clk_run), .dat_o(dat_o), .dat_oe(dat_oe),
        .dat_i(dat_i), .done(done), .status(status)
    );

    function automatic logic [7:0] pat(input int a, input int s);
        return 8'(((a * 37) + (s * 11) + 5) ^ (s << 2));
    endfunction

    // buffer model with one-cycle read latency
    always @(posedge clk) buf_data <= pat(int'(buf_addr), seed);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) bit_stb = 1'b1;
        @(negedge clk) bit_stb = 1'b0;
    endtask

    function automatic logic resp(input int k, input int d, input logic [2:0] code, input int l);
        if (k <= 2) return (d % 2 == 1) ? 1'b0 : 1'b1;
        if (k < 3 + d) return 1'b1;
        if (k == 3 + d) return 1'b0;
        if (k >= 4 + d && k <= 6 + d) return code[6 + d - k];
        if (k == 7 + d) return 1'b1;
        if (k >= 8 + d && k < 8 + d + l) return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_block(input int s, input int d, input logic [2:0] code, input int l);
        int errs;
        int offe;
        int kd;
        int ke;
        int exp_st;
        int got_st;
        logic [15:0] crc;
        logic b;
        logic fb;
        errs = 0;
        offe = 0;
        kd = -1;
        got_st = -1;
        crc = 16'h0000;
        seed = s;
        dat_i = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(card_clk_run == 1'b1, "R2 clk run after start", int'(card_clk_run), 1);
        strobe();
        if (!(dat_oe == 1'b1 && dat_o == 1'b0)) errs++;
        for (int i = 0; i < NB; i++) begin
            for (int j = 7; j >= 0; j--) begin
                b = pat(i, s)[j];
                fb = b ^ crc[15];
                crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
                strobe();
                if (!(dat_oe == 1'b1 && dat_o == b)) errs++;
            end
        end
        for (int j = 15; j >= 0; j--) begin
            strobe();
            if (!(dat_oe == 1'b1 && dat_o == crc[j])) errs++;
        end
        strobe();
        if (!(dat_oe == 1'b1 && dat_o == 1'b1)) errs++;
        chk(errs == 0, "R3 frame bit errors", errs, 0);

        if (d >= 8) begin
            ke = 10; exp_st = 3;
        end else if (code == 3'b010) begin
            if (l < LIMIT) begin ke = 8 + d + l; exp_st = 0; end
            else begin ke = 8 + d + LIMIT - 1; exp_st = 3; end
        end else begin
            ke = 7 + d; exp_st = (code == 3'b101) ? 1 : 2;
        end

        for (int k = 1; k <= ke + 2 && kd < 0; k++) begin
            dat_i = resp(k, d, code, l);
            strobe();
            if (k <= 2 && dat_oe != 1'b0) offe++;
            if (done) begin
                kd = k;
                got_st = int'(status);
            end
        end
        chk(offe == 0, "R4 released during turnaround", offe, 0);
        if (d >= 8)
            chk(kd == ke && got_st == exp_st, "R6 token timeout strobe/status", kd * 10 + got_st, ke * 10 + exp_st);
        else if (code != 3'b010)
            chk(kd == ke && got_st == exp_st, "R5 token error strobe/status", kd * 10 + got_st, ke * 10 + exp_st);
        else
            chk(kd == ke && got_st == exp_st, "R7 busy end strobe/status", kd * 10 + got_st, ke * 10 + exp_st);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
        chk(card_clk_run == 1'b0, "R2 clk run off after done", int'(card_clk_run), 0);
        dat_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(int'(status) == exp_st, "R8 status held", int'(status), exp_st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [2:0] codes [3];
        int lens [4];
        int s;
        codes[0] = 3'b010; codes[1] = 3'b101; codes[2] = 3'b110;
        lens[0] = 0; lens[1] = 1; lens[2] = LIMIT - 1; lens[3] = LIMIT;
        s = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dat_oe == 1'b0, "R1 reset oe", int'(dat_oe), 0);
        chk(dat_o == 1'b1, "R1 reset dat", int'(dat_o), 1);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(card_clk_run == 1'b0, "R1 reset clk run", int'(card_clk_run), 0);
        chk(status == 2'd0, "R1 reset status", int'(status), 0);
        for (int d = 0; d <= 8; d++) begin
            for (int c = 0; c < 3; c++) begin
                if (c == 0) begin
                    for (int li = 0; li < 4; li++) begin
                        run_block(s, d, codes[c], lens[li]);
                        s++;
                    end
                end else begin
                    run_block(s, d, codes[c], 0);
                    s++;
                end
            end
        end
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule